// File: doc/BRIEF.md
# LED Output Fault Scan Controller

This block is the digital control for a test mode that checks the LED sink outputs of a 24-channel constant-current driver for open-line and short faults. It contains the serial display chain with its parallel latch. It tracks whether the chip is in display mode or in scan mode. Scan mode is entered by holding a dedicated pin low, or by a five-cycle pattern on the two shared control pins (output enable and latch), each sampled on rising serial-clock edges. A second five-cycle pattern leaves scan mode.

In scan mode every output is forced on while the enable pin is low, and the block times the sensing window with a cycle counter. The analog comparators deliver per-channel open and short results as digital inputs. When the enable pin returns high after a long enough window, the per-channel verdicts are loaded into the serial chain in the same bit layout as display data. They then shift out on the serial output. An active-low error flag shows whether the last scan found any faulty channel.

Top module: `fault_scan_ctrl`

## Requirements
- R1: After synchronous reset (`rst` high at a rising edge) with `dm_n` high: `det_mode` is 0, `err_flag_n` is 1, `sdo` is 0 and `drive_on` is all zeros.
- R2: In display mode each rising edge shifts `sdi` into chain bit 0 and moves bit i to bit i+1; `sdo` is chain bit N-1. An edge with `latch_mode` high copies the chain (as it was before that edge) into the output latch. `drive_on` equals the latch while `oe_mode` is low and is all zeros while it is high.
- R3: The pairs (`oe_mode`,`latch_mode`) sampled on five consecutive edges as (1,0),(0,0),(1,0),(1,1),(1,0) put the block into scan mode; `det_mode` is 1 right after the fifth edge.
- R4: The pairs (1,0),(0,0),(1,0),(1,0),(1,0) on five consecutive edges return the block from sequence-entered scan mode to display mode right after the fifth edge.
- R5: An entry pattern while already in scan mode, or a resume pattern while in display mode, has no effect on `det_mode`.
- R6: A sample that breaks a partly matched pattern restarts matching. If that sample equals the first step (1,0), it counts as step one of a new attempt.
- R7: Holding `dm_n` low forces `det_mode` to 1 in the same cycle, without a clock edge. Releasing it returns `det_mode` to the sequence-controlled mode.
- R8: In scan mode `drive_on` is all ones while `oe_mode` is low and all zeros while it is high, whatever the latch holds.
- R9: The window length is WIN = ceil(CLK_MHZ*WINDOW_NS/1000) cycles (25 by default). A capture happens at an edge in scan mode where `oe_mode` is sampled high and was sampled low on at least WIN consecutive preceding edges. A shorter low period captures nothing, and the chain keeps shifting `sdi`.
- R10: At a capture, chain bit i becomes 1 when channel i has neither `open_flt[i]` nor `short_flt[i]` set, and 0 otherwise. `sdo` shows bit N-1 right after the capture edge, then each further edge brings the next lower bit.
- R11: `err_flag_n` goes low after a capture in which any channel is faulty and high after a capture in which none is. It holds its value between captures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sdi | input | 1 | Serial data input |
| latch_mode | input | 1 | Latch strobe, also part of the mode patterns |
| oe_mode | input | 1 | Output enable (active low), also part of the mode patterns |
| dm_n | input | 1 | Dedicated scan-mode request, active low |
| open_flt | input | N | Per-channel open-line / short-to-ground comparator result |
| short_flt | input | N | Per-channel shorted-LED comparator result |
| sdo | output | 1 | Serial data output (chain MSB) |
| drive_on | output | N | Per-channel current sink enable |
| det_mode | output | 1 | 1 while in scan mode |
| err_flag_n | output | 1 | Fault flag, low when the last scan found a fault |

## Verification
Mode changes from a pattern show on `det_mode` one register after the fifth sampled edge. The bench therefore checks each table vector one nanosecond after the edge that sampled it. `dm_n` and `oe_mode` act on `det_mode` and `drive_on` through logic only, so those checks follow a pin change with no clock edge in between. A capture loads the chain at the edge where `oe_mode` is first sampled high, so `sdo` and `err_flag_n` are read just after that edge, and each later bit just after one more edge. The window boundary is covered by low periods of exactly WIN-1 and WIN edges.

// File: rtl/fault_scan_pkg.sv
package fault_scan_pkg;

  localparam int SEQ_STEPS = 5;

  // Each step is {oe_mode, latch_mode}; step k sits at bits [2k+1:2k].
  localparam logic [2*SEQ_STEPS-1:0] ENTER_PAT  = 10'b10_11_10_00_10;
  localparam logic [2*SEQ_STEPS-1:0] RESUME_PAT = 10'b10_10_10_00_10;

  // Sensing window in clock cycles, rounded up.
  function automatic int win_cycles(input int clk_mhz, input int win_ns);
    return (clk_mhz * win_ns + 999) / 1000;
  endfunction

  // Per-channel verdict: 1 = healthy, 0 = open or short.
  function automatic logic chan_good(input logic open_f, input logic short_f);
    return !(open_f || short_f);
  endfunction

endpackage

// File: rtl/fault_scan_seq.sv
module fault_scan_seq #(
  parameter int STEPS = 5,
  parameter logic [2*STEPS-1:0] PAT = '0
) (
  input  logic clk,
  input  logic rst,
  input  logic oe,
  input  logic le,
  output logic hit
);
  localparam int IW = (STEPS > 1) ? $clog2(STEPS) : 1;

  logic [IW-1:0] idx;
  logic [1:0]    pair;
  logic [1:0]    want;
  logic          step_ok;
  logic          first_ok;

  assign pair     = {oe, le};
  assign want     = PAT[2*idx +: 2];
  assign step_ok  = (pair == want);
  assign first_ok = (pair == PAT[1:0]);
  assign hit      = step_ok && (idx == IW'(STEPS-1));

  always_ff @(posedge clk) begin
    if (rst) begin
      idx <= '0;
    end else if (step_ok) begin
      idx <= hit ? '0 : idx + 1'b1;
    end else begin
      idx <= first_ok ? IW'(1) : '0;
    end
  end

  // R6: a broken match never jumps ahead of step one
  a_r6_restart: assert property (@(posedge clk) disable iff (rst)
    (!step_ok) |=> (idx <= IW'(1)));

endmodule

// File: rtl/fault_scan_window.sv
module fault_scan_window #(
  parameter int WIN = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic det,
  input  logic oe,
  output logic cap
);
  localparam int CW = $clog2(WIN + 1);

  logic [CW-1:0] cnt;

  assign cap = det && oe && (cnt >= CW'(WIN));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (det && !oe) begin
      if (cnt != CW'(WIN)) cnt <= cnt + 1'b1;
    end else begin
      cnt <= '0;
    end
  end

  // R9: a capture follows a sampled-low enable
  a_r9_cap_after_low: assert property (@(posedge clk) disable iff (rst)
    cap |-> $past(!oe));

endmodule

// File: rtl/fault_scan_chain.sv
module fault_scan_chain #(
  parameter int N = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sdi,
  input  logic         le,
  input  logic         cap,
  input  logic [N-1:0] good,
  output logic         sdo,
  output logic [N-1:0] lat
);
  logic [N-1:0] sr;

  assign sdo = sr[N-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sr  <= '0;
      lat <= '0;
    end else begin
      if (cap) sr <= good;
      else     sr <= {sr[N-2:0], sdi};
      if (le)  lat <= sr;
    end
  end

  // R10: the top verdict appears on sdo right after a capture
  a_r10_load: assert property (@(posedge clk) disable iff (rst)
    cap |=> (sdo == $past(good[N-1])));

endmodule

// File: rtl/fault_scan_ctrl.sv
module fault_scan_ctrl
  import fault_scan_pkg::*;
#(
  parameter int N         = 24,
  parameter int CLK_MHZ   = 25,
  parameter int WINDOW_NS = 1000
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sdi,
  input  logic         latch_mode,
  input  logic         oe_mode,
  input  logic         dm_n,
  input  logic [N-1:0] open_flt,
  input  logic [N-1:0] short_flt,
  output logic         sdo,
  output logic [N-1:0] drive_on,
  output logic         det_mode,
  output logic         err_flag_n
);
  localparam int WIN = win_cycles(CLK_MHZ, WINDOW_NS);

  logic         enter_hit;
  logic         resume_hit;
  logic         seq_det;
  logic         cap;
  logic         err_q;
  logic [N-1:0] good;
  logic [N-1:0] lat;
  logic         any_bad;

  fault_scan_seq #(.STEPS(SEQ_STEPS), .PAT(ENTER_PAT)) u_enter (
    .clk(clk), .rst(rst), .oe(oe_mode), .le(latch_mode), .hit(enter_hit));

  fault_scan_seq #(.STEPS(SEQ_STEPS), .PAT(RESUME_PAT)) u_resume (
    .clk(clk), .rst(rst), .oe(oe_mode), .le(latch_mode), .hit(resume_hit));

  for (genvar i = 0; i < N; i++) begin : g_verdict
    assign good[i] = chan_good(open_flt[i], short_flt[i]);
  end

  assign any_bad = !(&good);

  always_ff @(posedge clk) begin
    if (rst) begin
      seq_det <= 1'b0;
    end else if (enter_hit && !seq_det) begin
      seq_det <= 1'b1;
    end else if (resume_hit && seq_det) begin
      seq_det <= 1'b0;
    end
  end

  assign det_mode = seq_det || !dm_n;

  fault_scan_window #(.WIN(WIN)) u_window (
    .clk(clk), .rst(rst), .det(det_mode), .oe(oe_mode), .cap(cap));

  fault_scan_chain #(.N(N)) u_chain (
    .clk(clk), .rst(rst), .sdi(sdi), .le(latch_mode), .cap(cap),
    .good(good), .sdo(sdo), .lat(lat));

  always_ff @(posedge clk) begin
    if (rst)      err_q <= 1'b0;
    else if (cap) err_q <= any_bad;
  end

  assign err_flag_n = !err_q;
  assign drive_on   = det_mode ? {N{!oe_mode}} : (lat & {N{!oe_mode}});

  // R3: a completed entry pattern lands in scan mode
  a_r3_enter: assert property (@(posedge clk) disable iff (rst)
    (enter_hit && !seq_det) |=> det_mode);

  // R4: a completed resume pattern leaves sequence scan mode
  a_r4_resume: assert property (@(posedge clk) disable iff (rst)
    (resume_hit && seq_det) |=> !seq_det);

  // R5: repeated patterns do not change the mode
  a_r5_no_reenter: assert property (@(posedge clk) disable iff (rst)
    (enter_hit && seq_det) |=> seq_det);
  a_r5_no_reresume: assert property (@(posedge clk) disable iff (rst)
    (resume_hit && !seq_det) |=> !seq_det);

  // R11: flag follows the verdicts of the last capture
  a_r11_flag: assert property (@(posedge clk) disable iff (rst)
    cap |=> (err_flag_n == !$past(any_bad)));

endmodule

// File: tb/fault_scan_ctrl_bench.sv
module fault_scan_ctrl_bench;
  localparam int N   = 24;
  localparam int WIN = 25;
  localparam int NV  = 47;

  // {oe_mode, latch_mode, expected det_mode after the edge}
  localparam logic [2:0] VEC [0:NV-1] = '{
    3'b100, 3'b000, 3'b100, 3'b110, 3'b101,            // R3 entry
    3'b101,                                            // idle
    3'b101, 3'b001, 3'b101, 3'b111, 3'b101,            // R5 entry again
    3'b101, 3'b001, 3'b101, 3'b101, 3'b100,            // R4 resume
    3'b100, 3'b000, 3'b100, 3'b100, 3'b100,            // R5 resume again
    3'b100, 3'b000, 3'b110,                            // R6 broken entry
    3'b100, 3'b000, 3'b100, 3'b110, 3'b101,            // entry
    3'b101, 3'b001, 3'b101, 3'b101, 3'b100,            // resume
    3'b100, 3'b000, 3'b100, 3'b100,                    // R6 break equal to step one
    3'b000, 3'b100, 3'b110, 3'b101,
    3'b101, 3'b001, 3'b101, 3'b101, 3'b100             // resume
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         sdi = 1'b0;
  logic         latch_mode = 1'b0;
  logic         oe_mode = 1'b1;
  logic         dm_n = 1'b1;
  logic [N-1:0] open_flt = '0;
  logic [N-1:0] short_flt = '0;
  logic         sdo;
  logic [N-1:0] drive_on;
  logic         det_mode;
  logic         err_flag_n;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  fault_scan_ctrl u_fault_scan_ctrl (
    .clk(clk), .rst(rst), .sdi(sdi), .latch_mode(latch_mode),
    .oe_mode(oe_mode), .dm_n(dm_n), .open_flt(open_flt),
    .short_flt(short_flt), .sdo(sdo), .drive_on(drive_on),
    .det_mode(det_mode), .err_flag_n(err_flag_n));

  task automatic check(input string req, input logic [N-1:0] act,
                       input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at the falling edge, clock once, settle past the edge
  task automatic step(input logic oe, input logic le, input logic d);
    @(negedge clk);
    oe_mode = oe; latch_mode = le; sdi = d;
    @(posedge clk);
    #1;
  endtask

  task automatic window(input int lows);
    for (int k = 0; k < lows; k++) step(1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0);
  endtask

  task automatic read_word(output logic [N-1:0] w);
    w[N-1] = sdo;
    for (int k = N-2; k >= 0; k--) begin
      step(1'b1, 1'b0, 1'b0);
      w[k] = sdo;
    end
  endtask

  initial begin
    logic [N-1:0] pat;
    logic [N-1:0] word;
    logic [N-1:0] expgood;

    repeat (3) @(posedge clk);
    #1;
    @(negedge clk); rst = 1'b0;
    #1;
    check("R1 det_mode", N'(det_mode), N'(0));
    check("R1 err_flag_n", N'(err_flag_n), N'(1));
    check("R1 sdo", N'(sdo), N'(0));
    check("R1 drive_on", drive_on, '0);

    // mode pattern table
    for (int v = 0; v < NV; v++) begin
      step(VEC[v][2], VEC[v][1], 1'b0);
      check($sformatf("R3/R4/R5/R6 mode vec %0d", v), N'(det_mode), N'(VEC[v][0]));
    end

    // R2 display shift and latch
    pat = 24'hA53C96;
    for (int k = N-1; k >= 0; k--) step(1'b1, 1'b0, pat[k]);
    check("R2 sdo msb", N'(sdo), N'(pat[N-1]));
    step(1'b1, 1'b1, 1'b0);
    @(negedge clk); oe_mode = 1'b0; latch_mode = 1'b0; #1;
    check("R2 drive_on latched", drive_on, pat);
    oe_mode = 1'b1; #1;
    check("R2 drive_on disabled", drive_on, '0);

    // R7 / R8 dedicated pin and forced outputs
    dm_n = 1'b0; #1;
    check("R7 dm_n forces scan", N'(det_mode), N'(1));
    oe_mode = 1'b0; #1;
    check("R8 all on", drive_on, '1);
    oe_mode = 1'b1; #1;
    check("R8 all off", drive_on, '0);

    // R9 / R10 / R11 capture with faults on channels 3 and 20
    open_flt = 24'h000008; short_flt = 24'h100000;
    expgood = ~(open_flt | short_flt);
    window(WIN);
    check("R11 flag low on fault", N'(err_flag_n), N'(0));
    read_word(word);
    check("R10 captured verdicts", word, expgood);

    // R9 window one short: nothing captured, chain keeps zeros
    for (int k = 0; k < N; k++) step(1'b1, 1'b0, 1'b0);
    open_flt = '0; short_flt = '0;
    window(WIN-1);
    read_word(word);
    check("R9 short window no capture", word, '0);
    check("R11 flag holds", N'(err_flag_n), N'(0));

    // R9 exact window with healthy channels
    window(WIN);
    check("R9 exact window sdo", N'(sdo), N'(1));
    check("R11 flag released", N'(err_flag_n), N'(1));
    read_word(word);
    check("R10 all healthy", word, '1);

    dm_n = 1'b1; #1;
    check("R7 release", N'(det_mode), N'(0));

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(10 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule